// File: doc/BRIEF.md
# PDM Test Pattern Generator

This block produces a synthetic pulse-density-modulated data line that imitates a stereo digital microphone. A PDM-to-PCM receive path can then be exercised with a known input. The block derives its own PDM clock from the fast interface clock. Each half of that clock carries one channel. The high half and the low half each have their own pattern mode, output delay and sine frequency exponent. The two channels therefore share one data line, interleaved.

A channel can output constant zeros, constant ones, an alternating bit stream, or a sine wave. The sine comes from a rotation (coupled-form) oscillator and is turned into one bit by a first-order sigma-delta modulator. When the enable input is low, the data line and the clock output stay low and all internal state returns to its start values. Every later enable therefore replays the same sequence. If both channels fall due in the same interface cycle, the high-phase channel drives the line.

Top module: `pdm_patgen`

## Requirements
- R1: While reset is asserted, and from the second interface edge after `enable` falls, `pdm_dat` and `pdm_clk` are 0.
- R2: One interface cycle after `enable` is sampled high, `pdm_clk` starts a period of P = `clk_div`+1 interface cycles. It is high for the first floor(P/2) cycles of each period and low for the rest.
- R3: Mode code 0 makes a channel drive 0, and mode code 1 makes it drive 1. `mode_*` is a 2-bit field.
- R4: Mode code 2 makes a channel drive 0, 1, 0, 1, … on its successive slots, starting with 0 after enable.
- R5: A high-phase delay of N updates `pdm_dat` N+1 interface cycles after `pdm_clk` rises.
- R6: A low-phase delay of N updates `pdm_dat` N+1 interface cycles after `pdm_clk` falls. If that point lies past the end of the period, it wraps into the next period.
- R7: A delay larger than the effective divider is treated as equal to the divider.
- R8: Mode code 3 drives a sigma-delta sine. On each slot: x ← x − (y>>>s), then y ← y + (x>>>s), with x starting at 24576 and y at 0. Then acc + (y + 32768) is formed in 17 bits. Bit 16 of that sum is the output bit, and the low 16 bits become the new acc. The oscillator and the accumulator advance on every slot of the channel, whatever its mode.
- R9: A sine exponent below 3 acts as 3, and one above 13 acts as 13.
- R10: A `clk_div` of 0 acts as 1, which gives a period of 2.
- R11: Dropping `enable` clears oscillator, accumulator, toggle and counter state, so a new enable repeats the same output sequence.
- R12: When both channels fall due in the same interface cycle, the high-phase channel's bit is driven and the low-phase channel still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_if | input | 1 | Fast interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Generator on/off |
| clk_div | input | 8 | PDM period minus one, in interface cycles |
| mode_hi | input | 2 | Pattern code of the high-phase channel |
| mode_lo | input | 2 | Pattern code of the low-phase channel |
| delay_hi | input | 8 | Drive delay of the high-phase channel |
| delay_lo | input | 8 | Drive delay of the low-phase channel |
| shift_hi | input | 4 | Sine frequency exponent, high phase |
| shift_lo | input | 4 | Sine frequency exponent, low phase |
| pdm_clk | output | 1 | Generated PDM clock |
| pdm_dat | output | 1 | PDM data line |

## Verification
Each channel's bit appears on `pdm_dat` in the interface cycle after the counter reaches that channel's slot. This is N+1 cycles after the relevant `pdm_clk` edge. `pdm_clk` follows the counter without a further register. `enable` acts one cycle later on the clock and two cycles later on the data line. The bench runs a cycle model of these latencies on the rising edge, using the requirement formulas. It compares both outputs against the model at every falling edge, and it changes inputs one time step after that falling edge. As a result, every comparison sees settled values from exactly the cycle the model predicts.

// File: rtl/pdm_patgen_pkg.sv
// Shared types and limits for the PDM test pattern generator.
package pdm_patgen_pkg;

    // Pattern selection per channel; the codes are visible at the ports.
    typedef enum logic [1:0] {
        PAT_ZERO = 2'd0,
        PAT_ONE  = 2'd1,
        PAT_ALT  = 2'd2,
        PAT_SINE = 2'd3
    } pat_mode_e;

    localparam int unsigned SHIFT_W   = 4;
    localparam int unsigned SHIFT_MIN = 3;
    localparam int unsigned SHIFT_MAX = 13;

    // Force a sine exponent into its legal window.
    function automatic logic [SHIFT_W-1:0] clamp_shift(input logic [SHIFT_W-1:0] s);
        if (s < SHIFT_W'(SHIFT_MIN))      return SHIFT_W'(SHIFT_MIN);
        else if (s > SHIFT_W'(SHIFT_MAX)) return SHIFT_W'(SHIFT_MAX);
        else                              return s;
    endfunction

endpackage

// File: rtl/pdm_phase_timer.sv
// Divides the interface clock into the PDM clock and marks the one
// interface cycle per period in which each channel's bit is launched.
// Assumes: the divider and the delays stay constant while running.
module pdm_phase_timer #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk_if,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_i,
    input  logic [DIV_W-1:0] dly_hi_i,
    input  logic [DIV_W-1:0] dly_lo_i,
    output logic             run_o,
    output logic             pdm_clk_o,
    output logic             strb_hi_o,
    output logic             strb_lo_o
);
    localparam int unsigned CW = DIV_W + 1;

    logic [DIV_W-1:0] div_eff, dhi_eff, dlo_eff, cnt;
    logic [CW-1:0]    per, half, lo_sum, t_hi, t_lo;
    logic             run;

    // Clamp the divider and the delays, and place both slots inside one period.
    always_comb begin
        div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
        dhi_eff = (dly_hi_i > div_eff) ? div_eff : dly_hi_i;
        dlo_eff = (dly_lo_i > div_eff) ? div_eff : dly_lo_i;
        per     = {1'b0, div_eff} + CW'(1);
        half    = per >> 1;
        lo_sum  = half + {1'b0, dlo_eff};
        t_hi    = {1'b0, dhi_eff};
        t_lo    = (lo_sum >= per) ? (lo_sum - per) : lo_sum;
    end

    // Period counter, held at zero while the generator is off.
    always_ff @(posedge clk_if) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else begin
            run <= enable;
            if (!run || cnt >= div_eff) cnt <= '0;
            else                        cnt <= cnt + DIV_W'(1);
        end
    end

    assign run_o     = run;
    assign pdm_clk_o = run && ({1'b0, cnt} < half);
    assign strb_hi_o = run && ({1'b0, cnt} == t_hi);
    assign strb_lo_o = run && ({1'b0, cnt} == t_lo);

endmodule

// File: rtl/pdm_sine_sd.sv
// Rotation oscillator followed by a first-order sigma-delta modulator.
// Advances one step per strobe; bit_o is the bit for the current step.
// Assumes: AMPLITUDE leaves headroom for the oscillator's slight overshoot.
module pdm_sine_sd
    import pdm_patgen_pkg::*;
#(
    parameter int unsigned SMP_W     = 16,
    parameter int          AMPLITUDE = 24576
) (
    input  logic               clk_if,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               step,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic               bit_o
);
    localparam logic signed [SMP_W-1:0] X_INIT = SMP_W'(AMPLITUDE);

    logic signed [SMP_W-1:0] x, y, xn, yn;
    logic        [SMP_W-1:0] acc, off;
    logic        [SMP_W:0]   sum;
    logic        [SHIFT_W-1:0] sh;

    // Next oscillator point and modulator sum.
    always_comb begin
        sh  = clamp_shift(shift_i);
        xn  = x - (y >>> sh);
        yn  = y + (xn >>> sh);
        off = {~yn[SMP_W-1], yn[SMP_W-2:0]};
        sum = {1'b0, acc} + {1'b0, off};
    end

    assign bit_o = sum[SMP_W];

    // Oscillator and accumulator state.
    always_ff @(posedge clk_if) begin
        if (!rst_n || clr) begin
            x   <= X_INIT;
            y   <= '0;
            acc <= '0;
        end else if (step) begin
            x   <= xn;
            y   <= yn;
            acc <= sum[SMP_W-1:0];
        end
    end

endmodule

// File: rtl/pdm_lane.sv
// One channel: chooses its bit according to the mode and advances its
// pattern state on every slot, whatever mode is selected.
module pdm_lane
    import pdm_patgen_pkg::*;
#(
    parameter int unsigned SMP_W     = 16,
    parameter int          AMPLITUDE = 24576
) (
    input  logic               clk_if,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               step,
    input  logic [1:0]         mode_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic               bit_o
);
    logic tog, sine_bit;
    pat_mode_e mode;

    pdm_sine_sd #(.SMP_W(SMP_W), .AMPLITUDE(AMPLITUDE)) sine_i (
        .clk_if (clk_if),
        .rst_n  (rst_n),
        .clr    (clr),
        .step   (step),
        .shift_i(shift_i),
        .bit_o  (sine_bit)
    );

    // Alternating-pattern state, starting at 0.
    always_ff @(posedge clk_if) begin
        if (!rst_n || clr) tog <= 1'b0;
        else if (step)     tog <= ~tog;
    end

    // Pattern selection.
    always_comb begin
        mode = pat_mode_e'(mode_i);
        unique case (mode)
            PAT_ZERO: bit_o = 1'b0;
            PAT_ONE:  bit_o = 1'b1;
            PAT_ALT:  bit_o = tog;
            default:  bit_o = sine_bit;
        endcase
    end

endmodule

// File: rtl/pdm_patgen.sv
// PDM test pattern generator top: one timer, two channel lanes (high
// phase = index 0, low phase = index 1), and the data line register.
// The high-phase channel wins when both slots coincide.
module pdm_patgen
    import pdm_patgen_pkg::*;
#(
    parameter int unsigned DIV_W     = 8,
    parameter int unsigned SMP_W     = 16,
    parameter int          AMPLITUDE = 24576
) (
    input  logic               clk_if,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [DIV_W-1:0]   clk_div,
    input  logic [1:0]         mode_hi,
    input  logic [1:0]         mode_lo,
    input  logic [DIV_W-1:0]   delay_hi,
    input  logic [DIV_W-1:0]   delay_lo,
    input  logic [SHIFT_W-1:0] shift_hi,
    input  logic [SHIFT_W-1:0] shift_lo,
    output logic               pdm_clk,
    output logic               pdm_dat
);
    localparam int unsigned NLANE = 2;

    logic               run, strb_hi, strb_lo;
    logic [NLANE-1:0]   strb, lane_bit;
    logic [1:0]         lane_mode  [NLANE];
    logic [SHIFT_W-1:0] lane_shift [NLANE];

    pdm_phase_timer #(.DIV_W(DIV_W)) timer_i (
        .clk_if   (clk_if),
        .rst_n    (rst_n),
        .enable   (enable),
        .div_i    (clk_div),
        .dly_hi_i (delay_hi),
        .dly_lo_i (delay_lo),
        .run_o    (run),
        .pdm_clk_o(pdm_clk),
        .strb_hi_o(strb_hi),
        .strb_lo_o(strb_lo)
    );

    assign strb          = {strb_lo, strb_hi};
    assign lane_mode[0]  = mode_hi;
    assign lane_mode[1]  = mode_lo;
    assign lane_shift[0] = shift_hi;
    assign lane_shift[1] = shift_lo;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        pdm_lane #(.SMP_W(SMP_W), .AMPLITUDE(AMPLITUDE)) lane_i (
            .clk_if (clk_if),
            .rst_n  (rst_n),
            .clr    (!run),
            .step   (strb[g]),
            .mode_i (lane_mode[g]),
            .shift_i(lane_shift[g]),
            .bit_o  (lane_bit[g])
        );
    end

    // Data line register: high-phase slot first, then low-phase slot.
    always_ff @(posedge clk_if) begin
        if (!rst_n || !run)  pdm_dat <= 1'b0;
        else if (strb_hi)    pdm_dat <= lane_bit[0];
        else if (strb_lo)    pdm_dat <= lane_bit[1];
    end

endmodule

// File: rtl/pdm_patgen_chk.sv
// Assertion checker for pdm_patgen, attached by bind.
module pdm_patgen_chk (
    input logic       clk_if,
    input logic       rst_n,
    input logic       enable,
    input logic [1:0] mode_hi,
    input logic       run,
    input logic       strb_hi,
    input logic       strb_lo,
    input logic       pdm_clk,
    input logic       pdm_dat
);
    // R1: a disabled generator keeps its data line low.
    a_r1_idle_low: assert property (@(posedge clk_if) disable iff (!rst_n)
        (!enable && $past(!enable)) |=> !pdm_dat);

    // R1: no PDM clock while stopped.
    a_r1_clk_idle: assert property (@(posedge clk_if) disable iff (!rst_n)
        !run |-> !pdm_clk);

    // R3: constant-one channel drives 1 in its slot.
    a_r3_const_one: assert property (@(posedge clk_if) disable iff (!rst_n)
        (strb_hi && mode_hi == 2'd1) |=> pdm_dat);

    // R3: constant-zero channel drives 0 in its slot.
    a_r3_const_zero: assert property (@(posedge clk_if) disable iff (!rst_n)
        (strb_hi && mode_hi == 2'd0) |=> !pdm_dat);

    // R5: the line only moves in a slot cycle.
    a_r5_hold: assert property (@(posedge clk_if) disable iff (!rst_n)
        (run && !strb_hi && !strb_lo) |=> $stable(pdm_dat));
endmodule

bind pdm_patgen pdm_patgen_chk chk_i (
    .clk_if (clk_if),
    .rst_n  (rst_n),
    .enable (enable),
    .mode_hi(mode_hi),
    .run    (run),
    .strb_hi(strb_hi),
    .strb_lo(strb_lo),
    .pdm_clk(pdm_clk),
    .pdm_dat(pdm_dat)
);

// File: tb/pdm_patgen_tb_top.sv
module pdm_patgen_tb_top;
    logic       clk_if = 1'b0;
    logic       rst_n  = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] clk_div = 8'd3;
    logic [1:0] mode_hi = 2'd0, mode_lo = 2'd0;
    logic [7:0] delay_hi = 8'd0, delay_lo = 8'd0;
    logic [3:0] shift_hi = 4'd3, shift_lo = 4'd3;
    logic       pdm_clk, pdm_dat;

    int    n_vec = 0, n_bad = 0;
    bit    chk_on = 1'b0;
    string cur_req = "R1";

    always #5 clk_if = ~clk_if;

    pdm_patgen dut_i (
        .clk_if(clk_if), .rst_n(rst_n), .enable(enable), .clk_div(clk_div),
        .mode_hi(mode_hi), .mode_lo(mode_lo), .delay_hi(delay_hi),
        .delay_lo(delay_lo), .shift_hi(shift_hi), .shift_lo(shift_lo),
        .pdm_clk(pdm_clk), .pdm_dat(pdm_dat)
    );

    // ---------------- reference model (from the requirements) ----------
    logic signed [15:0] mx [2];
    logic signed [15:0] my [2];
    int  macc [2];
    bit  mtog [2];
    bit  m_run, m_dat;
    int  m_cnt;

    function automatic int eff_div();
        return (clk_div == 0) ? 1 : int'(clk_div);
    endfunction

    function automatic int eff_shift(input logic [3:0] s);
        return (s < 3) ? 3 : ((s > 13) ? 13 : int'(s));
    endfunction

    function automatic void lane_clear(input int i);
        mx[i] = 16'sd24576; my[i] = 16'sd0; macc[i] = 0; mtog[i] = 1'b0;
    endfunction

    // Returns the lane's bit for this slot and advances its state.
    function automatic bit lane_step(input int i, input logic [1:0] md, input logic [3:0] s);
        int sh = eff_shift(s);
        logic signed [15:0] xn, yn;
        int sum;
        bit b;
        xn  = mx[i] - (my[i] >>> sh);
        yn  = my[i] + (xn >>> sh);
        sum = macc[i] + (int'(yn) + 32768);
        case (md)
            2'd0:    b = 1'b0;
            2'd1:    b = 1'b1;
            2'd2:    b = mtog[i];
            default: b = (sum >= 65536);
        endcase
        mx[i] = xn; my[i] = yn; macc[i] = sum & 65535; mtog[i] = ~mtog[i];
        return b;
    endfunction

    always @(posedge clk_if) begin
        int  d, per, half, dh, dl, tlo;
        bit  sh_hit, sl_hit, bh, bl;
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_dat = 0; lane_clear(0); lane_clear(1);
        end else begin
            d    = eff_div();
            per  = d + 1;
            half = per / 2;
            dh   = (int'(delay_hi) > d) ? d : int'(delay_hi);
            dl   = (int'(delay_lo) > d) ? d : int'(delay_lo);
            tlo  = half + dl;
            if (tlo >= per) tlo -= per;
            sh_hit = m_run && (m_cnt == dh);
            sl_hit = m_run && (m_cnt == tlo);
            if (!m_run) begin
                m_dat = 0; lane_clear(0); lane_clear(1);
            end else begin
                bh = 1'b0; bl = 1'b0;
                if (sh_hit) bh = lane_step(0, mode_hi, shift_hi);
                if (sl_hit) bl = lane_step(1, mode_lo, shift_lo);
                if (sh_hit)      m_dat = bh;
                else if (sl_hit) m_dat = bl;
            end
            if (!m_run || m_cnt >= d) m_cnt = 0; else m_cnt = m_cnt + 1;
            m_run = enable;
        end
    end

    // Compare both outputs away from the active edge.
    always @(negedge clk_if) begin
        bit exp_clk;
        if (chk_on) begin
            exp_clk = m_run && (m_cnt < (eff_div() + 1) / 2);
            n_vec++;
            if (pdm_dat !== m_dat || pdm_clk !== exp_clk) begin
                n_bad++;
                $display("FAIL %s t=%0t dat=%b clk=%b expected dat=%b clk=%b",
                         cur_req, $time, pdm_dat, pdm_clk, m_dat, exp_clk);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk_if);
        #1;
    endtask

    task automatic run_cfg(input string req, input int dv, input int mh, input int ml,
                           input int dh, input int dl, input int sh, input int sl,
                           input int cycles);
        cur_req  = req;
        clk_div  = 8'(dv);  mode_hi  = 2'(mh); mode_lo  = 2'(ml);
        delay_hi = 8'(dh);  delay_lo = 8'(dl);
        shift_hi = 4'(sh);  shift_lo = 4'(sl);
        enable   = 1'b1;
        wait_cyc(cycles);
        enable   = 1'b0;
        wait_cyc(3);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        wait_cyc(4);
        // R1: reset state at the ports.
        n_vec++;
        if (pdm_dat !== 1'b0 || pdm_clk !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset dat=%b clk=%b expected 0 0", pdm_dat, pdm_clk);
        end
        rst_n = 1'b1;
        chk_on = 1'b1;
        wait_cyc(3);
        run_cfg("R2", 5, 2, 2, 0, 0, 3, 3, 60);       // period and duty
        run_cfg("R3", 4, 1, 0, 1, 2, 3, 3, 50);       // constants
        run_cfg("R3", 4, 0, 1, 3, 0, 3, 3, 50);
        run_cfg("R4", 3, 2, 1, 0, 1, 3, 3, 40);       // alternating
        run_cfg("R5", 9, 1, 0, 7, 0, 3, 3, 80);       // late high slot
        run_cfg("R6", 9, 0, 1, 0, 9, 3, 3, 80);       // low slot wraps
        run_cfg("R7", 4, 2, 2, 200, 77, 3, 3, 60);    // delay clamp
        run_cfg("R8", 3, 3, 3, 1, 0, 3, 4, 3000);     // sine
        run_cfg("R8", 2, 3, 2, 0, 1, 6, 3, 2000);
        run_cfg("R9", 3, 3, 3, 0, 0, 0, 15, 2000);    // exponent clamp
        run_cfg("R10", 0, 2, 1, 0, 0, 3, 3, 40);      // divider clamp
        run_cfg("R11", 3, 3, 3, 0, 2, 5, 5, 400);     // restart replays
        run_cfg("R11", 3, 3, 3, 0, 2, 5, 5, 400);
        run_cfg("R12", 3, 2, 2, 2, 0, 3, 3, 60);      // coincident slots
        run_cfg("R2", 255, 2, 1, 10, 200, 3, 3, 1200);
        for (int k = 0; k < 30; k++) begin
            int dv = $urandom_range(0, 12);
            run_cfg("R5", dv, $urandom_range(0, 3), $urandom_range(0, 3),
                    $urandom_range(0, dv + 2), $urandom_range(0, dv + 2),
                    $urandom_range(0, 15), $urandom_range(0, 15),
                    40 * (dv + 2) + $urandom_range(0, 50));
        end
        cur_req = "R1";
        wait_cyc(10);
        chk_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule